// File: doc/BRIEF.md
# DRAM Strobe Timing Monitor

This block watches the row strobe, column strobe and write-enable pins of an asynchronous DRAM bus. It samples them on a fast reference clock and measures how long each strobe stays at each level. From the order of the strobe edges it works out what kind of cycle is under way: a row opened with no column yet, a single access, a fast-page sequence, or a refresh where the column strobe fell before the row strobe. It then applies only the timing rules that belong to that kind of cycle. It also follows the power-up sequence and checks that refresh cycles arrive often enough once the part is in service.

The monitor never drives the bus. Every limit is set as a parameter in picoseconds together with the reference clock period. Limits are turned into sample counts, rounded up for minimums and down for maximums. Each rule has one bit in a sticky error vector, which stays set until `clr` is pulsed. A separate vector gives a one-cycle pulse for each violation as it is detected, two clock edges after the offending pin change reaches the block.

Top module: `dram_timing_monitor`

## Requirements
- R1: If the row strobe stays high for fewer than the precharge minimum (TRP) before it falls, bit 0 is set.
- R2: If the row strobe stays low for fewer than the active minimum (TRAS_MIN) before it rises, bit 1 is set.
- R3: A row-low time above its maximum sets bit 2. The maximum is TRAS_MAX, except in a page cycle, where it is TRASP_MAX. A page cycle is a row period in which the column strobe fell a second time.
- R4: In a non-refresh cycle, a column-strobe low time shorter than TCAS sets bit 3.
- R5: While a row is open and after its first column access, a column-strobe high time shorter than TCP before the next column fall sets bit 4.
- R6: In a non-refresh cycle, write-enable falling while the column strobe was already low (a late write) sets bit 5. Write-enable falling at the same time as, or before, the column fall is allowed.
- R7: A row fall while the column strobe is already low starts a refresh cycle. In that cycle, a column-low lead of fewer than TCSR samples before the row fall sets bit 6.
- R8: In a refresh cycle, if the column strobe rises fewer than TCHR samples after the row fall, bit 7 is set.
- R9: Once start-up is complete, the time is cut into back-to-back windows of REF_WIN. Any window holding fewer than REF_NEED completed refresh cycles sets bit 8. Both kinds of refresh count: a row cycle with no column access, and a refresh cycle.
- R10: After reset, bit 9 is set by a first column access (a column fall in a freshly opened row) in either of two cases: it comes before the INIT_WAIT pause has elapsed, or it comes before INIT_CYCLES row cycles have completed after that pause.
- R11: After reset, both error vectors are zero. A sticky bit is set only with its pulse and stays set until `clr` is pulsed.
- R12: Rules for non-refresh cycles (R4, R6) are not applied inside a refresh cycle, and refresh rules are not applied outside one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | One-cycle pulse that clears the sticky error vector |
| ras_n | input | 1 | Observed row strobe, active low |
| cas_n | input | 1 | Observed column strobe, active low |
| we_n | input | 1 | Observed write enable, active low |
| err_sticky | output | 10 | Sticky violation bits, bit n as listed in the requirements |
| err_pulse | output | 10 | One-cycle pulse per newly detected violation |

## Verification
The assertions assume reset is asserted before any strobe activity, so the cycle tracker starts idle and has a known row level. They also assume that a row-strobe edge and a column-strobe edge never land in the same sample in a way that would make the cycle type ambiguous. The stimulus drives every pin change on the falling clock edge and holds each level for a whole number of cycles. It never changes the row and column strobes together except where a cycle closes. Each scenario ends with a row-high period longer than the precharge minimum, so that the next scenario starts clean.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    localparam int NRULE       = 10;
    localparam int B_PRECHG    = 0;
    localparam int B_RAS_SHORT = 1;
    localparam int B_RAS_LONG  = 2;
    localparam int B_CAS_SHORT = 3;
    localparam int B_CAS_PRE   = 4;
    localparam int B_LATE_WE   = 5;
    localparam int B_CBR_SETUP = 6;
    localparam int B_CBR_HOLD  = 7;
    localparam int B_REF_UNDER = 8;
    localparam int B_INIT      = 9;

    typedef enum logic [2:0] {
        CS_IDLE,   // row strobe high
        CS_OPEN,   // row low, no column access yet
        CS_ACC,    // one column access seen
        CS_PAGE,   // second column fall in same row
        CS_CBR     // column led row: refresh
    } cyc_state_t;

    typedef enum logic [1:0] {
        IS_WAIT,   // power-up pause
        IS_WAKE,   // counting wake-up row cycles
        IS_READY   // in service, refresh watch armed
    } init_state_t;

    function automatic longint unsigned cdiv(input longint unsigned a, input longint unsigned b);
        return (a + b - 1) / b;
    endfunction

    function automatic longint unsigned fdiv(input longint unsigned a, input longint unsigned b);
        return a / b;
    endfunction

endpackage

// File: rtl/dtm_run_counter.sv
module dtm_run_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lvl_change,
    output logic [W-1:0] run_len
);
    // Counts samples spent at the current level; saturates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '1;
        end else if (lvl_change) begin
            run_len <= W'(1);
        end else if (run_len != '1) begin
            run_len <= run_len + 1'b1;
        end
    end
endmodule

// File: rtl/dtm_cycle_fsm.sv
module dtm_cycle_fsm
    import dtm_pkg::*;
#(
    parameter int unsigned TRP_C      = 16,
    parameter int unsigned TRAS_MIN_C = 24,
    parameter int unsigned TRAS_MAX_C = 4000,
    parameter int unsigned TRASP_C    = 80000,
    parameter int unsigned TCAS_C     = 6,
    parameter int unsigned TCP_C      = 4,
    parameter int unsigned TCSR_C     = 2,
    parameter int unsigned TCHR_C     = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s_ras,
    input  logic       p_ras,
    input  logic       s_cas,
    input  logic       p_cas,
    input  logic       s_we,
    input  logic       p_we,
    output cyc_state_t state,
    output logic [7:0] rule_ev,
    output logic       ras_rise,
    output logic       ref_done,
    output logic       access
);
    localparam int CMAX = (TCAS_C > TCP_C) ? ((TCAS_C > TCSR_C) ? TCAS_C : TCSR_C)
                                           : ((TCP_C > TCSR_C) ? TCP_C : TCSR_C);
    localparam int RW = $clog2(TRASP_C + 2);
    localparam int CW = $clog2(CMAX + 2);

    cyc_state_t    state_q, state_d;
    logic [RW-1:0] ras_len;
    logic [CW-1:0] cas_len;
    logic          ras_fall, cas_fall, cas_rise, we_fall, cas_held;

    assign ras_fall = p_ras & ~s_ras;
    assign ras_rise = ~p_ras & s_ras;
    assign cas_fall = p_cas & ~s_cas;
    assign cas_rise = ~p_cas & s_cas;
    assign we_fall  = p_we & ~s_we;
    assign cas_held = ~p_cas & ~s_cas;

    dtm_run_counter #(.W(RW)) u_ras_run (
        .clk(clk), .rst_n(rst_n), .lvl_change(s_ras != p_ras), .run_len(ras_len));
    dtm_run_counter #(.W(CW)) u_cas_run (
        .clk(clk), .rst_n(rst_n), .lvl_change(s_cas != p_cas), .run_len(cas_len));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE: if (ras_fall) state_d = cas_held ? CS_CBR : CS_OPEN;
            CS_OPEN: if (ras_rise) state_d = CS_IDLE;
                     else if (cas_fall) state_d = CS_ACC;
            CS_ACC:  if (ras_rise) state_d = CS_IDLE;
                     else if (cas_fall) state_d = CS_PAGE;
            CS_PAGE: if (ras_rise) state_d = CS_IDLE;
            CS_CBR:  if (ras_rise) state_d = CS_IDLE;
            default: state_d = CS_IDLE;
        endcase
    end

    always_comb begin
        rule_ev = '0;
        unique case (state_q)
            CS_IDLE: begin
                if (ras_fall) begin
                    rule_ev[B_PRECHG] = ras_len < RW'(TRP_C);
                    if (cas_held) rule_ev[B_CBR_SETUP] = cas_len < CW'(TCSR_C);
                end
            end
            CS_OPEN, CS_ACC, CS_PAGE: begin
                if (ras_rise) begin
                    rule_ev[B_RAS_SHORT] = ras_len < RW'(TRAS_MIN_C);
                    rule_ev[B_RAS_LONG]  = (state_q == CS_PAGE) ? (ras_len > RW'(TRASP_C))
                                                                : (ras_len > RW'(TRAS_MAX_C));
                end
                if (cas_rise) rule_ev[B_CAS_SHORT] = cas_len < CW'(TCAS_C);
                if (cas_fall && state_q != CS_OPEN) rule_ev[B_CAS_PRE] = cas_len < CW'(TCP_C);
                if (we_fall && cas_held) rule_ev[B_LATE_WE] = 1'b1;
            end
            CS_CBR: begin
                if (ras_rise) begin
                    rule_ev[B_RAS_SHORT] = ras_len < RW'(TRAS_MIN_C);
                    rule_ev[B_RAS_LONG]  = ras_len > RW'(TRAS_MAX_C);
                end
                if (cas_rise) rule_ev[B_CBR_HOLD] = ras_len < RW'(TCHR_C);
            end
            default: rule_ev = '0;
        endcase
    end

    assign state    = state_q;
    assign ref_done = ras_rise && (state_q == CS_OPEN || state_q == CS_CBR);
    assign access   = cas_fall && (state_q == CS_OPEN);
endmodule

// File: rtl/dtm_init_ref.sv
module dtm_init_ref
    import dtm_pkg::*;
#(
    parameter int unsigned WAIT_C   = 80000,
    parameter int unsigned WAKE_N   = 8,
    parameter int unsigned WIN_C    = 6400000,
    parameter int unsigned REF_NEED = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_rise,
    input  logic ref_done,
    input  logic access,
    output logic ready,
    output logic init_viol,
    output logic ref_under
);
    localparam int WTW = $clog2(WAIT_C + 1);
    localparam int WKW = $clog2(WAKE_N + 1);
    localparam int WNW = $clog2(WIN_C + 1);
    localparam int RFW = $clog2(REF_NEED + 1);

    init_state_t    st_q, st_d;
    logic [WTW-1:0] wait_q;
    logic [WKW-1:0] wake_q;
    logic [WNW-1:0] win_q;
    logic [RFW-1:0] refs_q;
    logic [RFW:0]   refs_eff;
    logic           win_end;

    assign win_end  = (win_q == WNW'(WIN_C - 1));
    assign refs_eff = {1'b0, refs_q} + {{RFW{1'b0}}, ref_done};

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IS_WAIT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IS_WAIT:  if (wait_q == WTW'(WAIT_C - 1)) st_d = IS_WAKE;
            IS_WAKE:  if (ras_rise && wake_q == WKW'(WAKE_N - 1)) st_d = IS_READY;
            IS_READY: st_d = IS_READY;
            default:  st_d = IS_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            wake_q <= '0;
            win_q  <= '0;
            refs_q <= '0;
        end else begin
            if (st_q == IS_WAIT) wait_q <= wait_q + 1'b1;
            if (st_q == IS_WAKE && ras_rise) wake_q <= wake_q + 1'b1;
            if (st_q == IS_READY) begin
                if (win_end) begin
                    win_q  <= '0;
                    refs_q <= '0;
                end else begin
                    win_q <= win_q + 1'b1;
                    if (ref_done && refs_q != RFW'(REF_NEED)) refs_q <= refs_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        ready     = (st_q == IS_READY);
        init_viol = access && (st_q != IS_READY);
        ref_under = (st_q == IS_READY) && win_end && (refs_eff < (RFW + 1)'(REF_NEED));
    end
endmodule

// File: rtl/dram_timing_monitor.sv
module dram_timing_monitor
    import dtm_pkg::*;
#(
    parameter longint unsigned CLK_PS       = 2500,
    parameter longint unsigned TRP_PS       = 40000,
    parameter longint unsigned TRAS_MIN_PS  = 60000,
    parameter longint unsigned TRAS_MAX_PS  = 10000000,
    parameter longint unsigned TRASP_PS     = 200000000,
    parameter longint unsigned TCAS_PS      = 15000,
    parameter longint unsigned TCP_PS       = 10000,
    parameter longint unsigned TCSR_PS      = 5000,
    parameter longint unsigned TCHR_PS      = 15000,
    parameter longint unsigned REF_WIN_PS   = 64'd16000000000,
    parameter int unsigned     REF_NEED     = 1024,
    parameter longint unsigned INIT_WAIT_PS = 200000000,
    parameter int unsigned     INIT_CYCLES  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    output logic [NRULE-1:0] err_sticky,
    output logic [NRULE-1:0] err_pulse
);
    // Minimums round up, maximums and the refresh window round down.
    localparam int unsigned TRP_C      = int'(cdiv(TRP_PS, CLK_PS));
    localparam int unsigned TRAS_MIN_C = int'(cdiv(TRAS_MIN_PS, CLK_PS));
    localparam int unsigned TRAS_MAX_C = int'(fdiv(TRAS_MAX_PS, CLK_PS));
    localparam int unsigned TRASP_C    = int'(fdiv(TRASP_PS, CLK_PS));
    localparam int unsigned TCAS_C     = int'(cdiv(TCAS_PS, CLK_PS));
    localparam int unsigned TCP_C      = int'(cdiv(TCP_PS, CLK_PS));
    localparam int unsigned TCSR_C     = int'(cdiv(TCSR_PS, CLK_PS));
    localparam int unsigned TCHR_C     = int'(cdiv(TCHR_PS, CLK_PS));
    localparam int unsigned WIN_C      = int'(fdiv(REF_WIN_PS, CLK_PS));
    localparam int unsigned WAIT_C     = int'(cdiv(INIT_WAIT_PS, CLK_PS));

    logic             s_ras, s_cas, s_we, p_ras, p_cas, p_we;
    cyc_state_t       cyc_state;
    logic [7:0]       rule_ev;
    logic             ras_rise, ref_done, access;
    logic             init_ready, init_viol, ref_under;
    logic [NRULE-1:0] ev_all;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {s_ras, s_cas, s_we} <= 3'b111;
            {p_ras, p_cas, p_we} <= 3'b111;
        end else begin
            {s_ras, s_cas, s_we} <= {ras_n, cas_n, we_n};
            {p_ras, p_cas, p_we} <= {s_ras, s_cas, s_we};
        end
    end

    dtm_cycle_fsm #(
        .TRP_C(TRP_C), .TRAS_MIN_C(TRAS_MIN_C), .TRAS_MAX_C(TRAS_MAX_C), .TRASP_C(TRASP_C),
        .TCAS_C(TCAS_C), .TCP_C(TCP_C), .TCSR_C(TCSR_C), .TCHR_C(TCHR_C)
    ) u_cycle (
        .clk(clk), .rst_n(rst_n),
        .s_ras(s_ras), .p_ras(p_ras), .s_cas(s_cas), .p_cas(p_cas), .s_we(s_we), .p_we(p_we),
        .state(cyc_state), .rule_ev(rule_ev), .ras_rise(ras_rise), .ref_done(ref_done),
        .access(access)
    );

    dtm_init_ref #(
        .WAIT_C(WAIT_C), .WAKE_N(INIT_CYCLES), .WIN_C(WIN_C), .REF_NEED(REF_NEED)
    ) u_init_ref (
        .clk(clk), .rst_n(rst_n), .ras_rise(ras_rise), .ref_done(ref_done), .access(access),
        .ready(init_ready), .init_viol(init_viol), .ref_under(ref_under)
    );

    assign ev_all = {init_viol, ref_under, rule_ev};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse  <= '0;
            err_sticky <= '0;
        end else begin
            err_pulse  <= ev_all;
            err_sticky <= (clr ? '0 : err_sticky) | ev_all;
        end
    end
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker
    import dtm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic [NRULE-1:0] err_sticky,
    input logic [NRULE-1:0] err_pulse,
    input logic             p_ras,
    input logic             s_cas,
    input cyc_state_t       state,
    input logic             init_ready
);
    AST_STICKY_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_sticky & ~$past(err_sticky) & ~err_pulse) == '0)); // R11
    AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((err_sticky & ~err_pulse) == '0)); // R11
    AST_STATE_FOLLOWS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == CS_IDLE) == p_ras)); // R12
    AST_REFRESH_NEEDS_CAS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_CBR && $past(state) != CS_CBR) |-> !$past(s_cas)); // R7
    AST_UNDERRUN_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse[B_REF_UNDER] |-> init_ready); // R9
    AST_INIT_ONLY_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse[B_INIT] |-> !$past(init_ready)); // R10
    AST_PAGE_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_PAGE) |-> ($past(state) == CS_ACC || $past(state) == CS_PAGE)); // R3
endmodule

bind dram_timing_monitor dtm_checker u_dtm_checker (
    .clk(clk), .rst_n(rst_n), .clr(clr), .err_sticky(err_sticky), .err_pulse(err_pulse),
    .p_ras(p_ras), .s_cas(s_cas), .state(cyc_state), .init_ready(init_ready)
);

// File: tb/test_dram_timing_monitor.sv
module test_dram_timing_monitor;
    import dtm_pkg::*;

    // Bench scale: 10 ns clock; limits in samples: TRP 4, TRAS 6..30, page 100,
    // TCAS 3, TCP 2, TCSR 2, TCHR 3, window 400 with 4 refreshes, wait 50, wake 8.
    localparam logic [NRULE-1:0] MASK = ~(NRULE'(1) << B_REF_UNDER);

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [NRULE-1:0] err_sticky, err_pulse;
    int checks = 0, fails = 0, pre_pulses = 0, cyc = 0;
    bit done = 1'b0;

    dram_timing_monitor #(
        .CLK_PS(10000), .TRP_PS(40000), .TRAS_MIN_PS(60000), .TRAS_MAX_PS(300000),
        .TRASP_PS(1000000), .TCAS_PS(30000), .TCP_PS(20000), .TCSR_PS(20000),
        .TCHR_PS(30000), .REF_WIN_PS(4000000), .REF_NEED(4), .INIT_WAIT_PS(500000),
        .INIT_CYCLES(8)
    ) i_dram_timing_monitor (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .err_sticky(err_sticky), .err_pulse(err_pulse)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (err_pulse[B_PRECHG]) pre_pulses <= pre_pulses + 1;
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [NRULE-1:0] act, input logic [NRULE-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic clear_err();
        clr = 1'b1; hold(1); clr = 1'b0; hold(1);
    endtask

    task automatic expect_bits(input string req, input logic [NRULE-1:0] exp);
        hold(3);
        check(req, err_sticky & MASK, exp);
        clear_err();
    endtask

    task automatic access(input int rcd, input int cl);
        ras_n = 1'b0; hold(rcd);
        cas_n = 1'b0; hold(cl);
        cas_n = 1'b1; ras_n = 1'b1; hold(6);
    endtask

    task automatic page(input int n, input int m, input int hi);
        ras_n = 1'b0; hold(2);
        for (int k = 0; k < n; k++) begin
            cas_n = 1'b0; hold(3);
            cas_n = 1'b1; hold(hi);
        end
        cas_n = 1'b0; hold(m);
        cas_n = 1'b1; ras_n = 1'b1; hold(6);
    endtask

    task automatic refresh_cbr(input int lead, input int hold_after, input int tail);
        cas_n = 1'b0; hold(lead);
        ras_n = 1'b0; hold(hold_after);
        cas_n = 1'b1; hold(tail);
        ras_n = 1'b1; hold(6);
    endtask

    task automatic bit1(output logic [NRULE-1:0] v, input int b);
        v = '0; v[b] = 1'b1;
    endtask

    initial begin
        logic [NRULE-1:0] e;
        hold(3);
        check("R11 reset sticky", err_sticky, '0);
        check("R11 reset pulse", err_pulse, '0);
        rst_n = 1'b1;
        hold(5);
        // R10: access during the power-up pause
        access(2, 5);
        bit1(e, B_INIT); expect_bits("R10 access in pause", e);
        hold(50);
        for (int k = 0; k < 7; k++) begin
            ras_n = 1'b0; hold(8); ras_n = 1'b1; hold(6);
        end
        access(2, 5);                       // 8th cycle: too early
        bit1(e, B_INIT); expect_bits("R10 access in 8th cycle", e);
        access(2, 5);                       // after 8 completed cycles
        expect_bits("R10 access after wake-up", '0);
        // R1 precharge
        pre_pulses = 0;
        ras_n = 1'b0; hold(7); ras_n = 1'b1; hold(3);
        access(2, 5);
        hold(2);
        checks++;
        if (pre_pulses != 1) begin
            fails++;
            $display("FAIL R1 pulse count: actual %0d expected 1", pre_pulses);
        end
        bit1(e, B_PRECHG); expect_bits("R1 short precharge", e);
        ras_n = 1'b0; hold(7); ras_n = 1'b1; hold(4);
        access(2, 5);
        expect_bits("R1 precharge at limit", '0);
        // R11 clear
        ras_n = 1'b0; hold(7); ras_n = 1'b1; hold(3);
        access(2, 5);
        clear_err();
        hold(2);
        check("R11 cleared", err_sticky & MASK, '0);
        // R2
        access(2, 3);
        bit1(e, B_RAS_SHORT); expect_bits("R2 row low 5", e);
        access(3, 3);
        expect_bits("R2 row low 6", '0);
        // R3
        access(2, 29);
        bit1(e, B_RAS_LONG); expect_bits("R3 row low 31", e);
        access(2, 28);
        expect_bits("R3 row low 30", '0);
        page(11, 3, 2);
        expect_bits("R3 page row low 60", '0);
        page(19, 4, 2);
        bit1(e, B_RAS_LONG); expect_bits("R3 page row low 101", e);
        // R4
        ras_n = 1'b0; hold(3); cas_n = 1'b0; hold(2); cas_n = 1'b1; hold(2);
        ras_n = 1'b1; hold(6);
        bit1(e, B_CAS_SHORT); expect_bits("R4 column low 2", e);
        // R5
        page(1, 3, 1);
        bit1(e, B_CAS_PRE); expect_bits("R5 column high 1", e);
        // R6
        ras_n = 1'b0; hold(2); cas_n = 1'b0; hold(2); we_n = 1'b0; hold(2);
        cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; hold(6);
        bit1(e, B_LATE_WE); expect_bits("R6 late write", e);
        ras_n = 1'b0; hold(2); cas_n = 1'b0; we_n = 1'b0; hold(4);
        cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; hold(6);
        expect_bits("R6 early write", '0);
        // R7
        refresh_cbr(1, 3, 5);
        bit1(e, B_CBR_SETUP); expect_bits("R7 lead 1", e);
        refresh_cbr(2, 3, 5);
        expect_bits("R7 lead 2", '0);
        // R8
        refresh_cbr(2, 2, 6);
        bit1(e, B_CBR_HOLD); expect_bits("R8 hold 2", e);
        // R12: write-enable activity inside a refresh
        cas_n = 1'b0; hold(2); ras_n = 1'b0; hold(2); we_n = 1'b0; hold(2);
        we_n = 1'b1; cas_n = 1'b1; hold(4); ras_n = 1'b1; hold(6);
        expect_bits("R12 refresh ignores write rules", '0);
        // R9: exactly four refreshes per 400-sample window, then none
        for (int k = 0; k < 5; k++) begin
            ras_n = 1'b0; hold(8); ras_n = 1'b1; hold(92);
        end
        clear_err();
        for (int k = 0; k < 8; k++) begin
            ras_n = 1'b0; hold(8); ras_n = 1'b1; hold(92);
        end
        check("R9 four per window", err_sticky, '0);
        hold(900);
        e = '0; e[B_REF_UNDER] = 1'b1;
        check("R9 starved window", err_sticky, e);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        hold(50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule